// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block looks for the reference divider M, feedback multiplier N and post-divider index PL of a frequency synthesizer that bring the output nearest to a requested frequency. A caller presents the target and the reference frequency, both in kHz, and pulses `start`. The engine then walks a nested sweep: post-divider index on the outside, M in the middle, and at most two N values on the inside. When the sweep is over it pulses `done` and presents the winning coefficients.

Each candidate must meet several limits. The comparison frequency (reference over M) must lie inside its window, the coefficients must lie inside their ranges, and the VCO frequency must lie inside its window. The upper edge of that VCO window is raised when the padded target lies above it. The post-divider index maps to a divide ratio through a fixed table that is not monotonic. All quotients come from one shared iterative divider. The sweep stops early once a candidate with zero error appears.

Top module: `pll_coef_search`

## Requirements
- R1: While reset is held and after it is released, m_out, n_out, pl_out, done, busy and no_sol are all 0.
- R2: A `start` seen while idle latches target_khz and ref_khz and raises busy on the next cycle. A `start` seen while busy has no effect: the result reported matches the first request.
- R3: `done` is high for exactly one cycle, in the cycle where busy has just fallen. m_out, n_out, pl_out and no_sol change only in a cycle where done is high, and otherwise hold their value.
- R4: PL index i maps to ratio 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32 for i = 0..14. With W = target + floor(target/50) and Vhi = max(2,064,000, W), the swept indices run from first(floor(1,000,000/W)) to first(ceil(Vhi/W)). Each bound is clamped to 1..32 before mapping. first(b) is the lowest index in 0..13 whose ratio is at least b, or 14 if there is none.
- R5: An M in 1..255 is tried only if floor(ref/M) lies in 12,000..38,000 kHz.
- R6: For each PL and M, the only N values tried are floor and ceil of target×ratio×M/ref. An M whose floor exceeds 255 is skipped, and an N outside 8..255 is skipped.
- R7: A candidate counts only if floor(ref×N/M) lies between 1,000,000 kHz and Vhi inclusive.
- R8: The estimate is floor((VCO + floor(ratio/2))/ratio). Its error is the absolute difference from the target. In sweep order (PL ascending, then M, then N), a candidate replaces the best only when its error is strictly smaller. The reported result equals this minimum-error choice.
- R9: If no candidate qualifies, no_sol is 1 and the result reads M=255, N=8, PL=1. Otherwise no_sol is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search; ignored while busy |
| target_khz | input | 24 | Wanted output frequency in kHz (at least 1) |
| ref_khz | input | 24 | Reference frequency in kHz (at least 1) |
| m_out | output | 8 | Chosen reference divider |
| n_out | output | 8 | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider index |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| no_sol | output | 1 | No candidate met the limits |

## Verification
The assertions watch the handshake on every cycle. They check that done lasts one cycle and ends busy, and that a start from idle makes the engine busy. They check that the results hold between done pulses, that a reported solution has coefficients in range, and that the fallback values appear when nothing qualified. They also check that the shared divider is never relaunched mid-division and that every accepted candidate's VCO lies inside the possibly raised window. Whether the chosen triple really is the minimum-error one under the non-monotonic ratio table, the floor/ceil N pair and rounded estimate can only be shown by the bench's scenarios against its independent sweep model. The same holds for the early stop on an exact hit and for a start ignored mid-search.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int PL_LAST      = 14;
  localparam int BOUND_MAX    = 32;
  localparam int MARGIN_DIV   = 50;

  typedef enum logic [3:0] {
    S_IDLE, S_PCT, S_HI, S_LO, S_PLSET, S_MCHK, S_NDIV,
    S_NCHK, S_VDIV, S_ODIV, S_NNEXT, S_MNEXT, S_PLNEXT, S_FIN
  } srch_st_e;

  // divide ratio selected by a post-divider index
  function automatic logic [5:0] pl_ratio(input logic [3:0] idx);
    case (idx)
      4'd0:  return 6'd1;
      4'd1:  return 6'd2;
      4'd2:  return 6'd3;
      4'd3:  return 6'd4;
      4'd4:  return 6'd5;
      4'd5:  return 6'd6;
      4'd6:  return 6'd8;
      4'd7:  return 6'd10;
      4'd8:  return 6'd12;
      4'd9:  return 6'd16;
      4'd10: return 6'd12;
      4'd11: return 6'd16;
      4'd12: return 6'd20;
      4'd13: return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // lowest index below the last whose ratio reaches the bound, else the last
  function automatic logic [3:0] pl_first_idx(input logic [5:0] bound);
    logic [3:0] idx;
    idx = 4'(PL_LAST);
    for (int i = PL_LAST - 1; i >= 0; i--)
      if (pl_ratio(4'(i)) >= bound) idx = 4'(i);
    return idx;
  endfunction

endpackage

// File: rtl/pll_div.sv
module pll_div #(
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic          busy,
  output logic          done
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   acc, q, d;
  logic [CNTW-1:0] cnt;

  logic [DW:0] sh, diff;
  logic        fit;
  assign sh   = {acc, q[DW-1]};
  assign diff = sh - {1'b0, d};
  assign fit  = !diff[DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      q    <= '0;
      d    <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (go) begin
      acc  <= '0;
      q    <= dividend;
      d    <= divisor;
      cnt  <= CNTW'(DW);
      done <= 1'b0;
    end else if (cnt != '0) begin
      acc  <= fit ? diff[DW-1:0] : sh[DW-1:0];
      q    <= {q[DW-2:0], fit};
      cnt  <= cnt - 1'b1;
      done <= (cnt == CNTW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = q;
  assign rem  = acc;
  assign busy = (cnt != '0);
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int DW = 40
) (
  input  logic [DW-1:0] cand,
  input  logic [DW-1:0] win_lo,
  input  logic [DW-1:0] win_hi,
  input  logic [DW-1:0] goal,
  output logic          in_win,
  output logic [DW-1:0] err
);
  assign in_win = (cand >= win_lo) && (cand <= win_hi);
  assign err    = (cand >= goal) ? (cand - goal) : (goal - cand);
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_search_pkg::*;
#(
  parameter int FW      = 24,
  parameter int CW      = 8,
  parameter int DW      = 40,
  parameter int VCO_MIN = 1000000,
  parameter int VCO_MAX = 2064000,
  parameter int U_MIN   = 12000,
  parameter int U_MAX   = 38000,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] target_khz,
  input  logic [FW-1:0] ref_khz,
  output logic [CW-1:0] m_out,
  output logic [CW-1:0] n_out,
  output logic [3:0]    pl_out,
  output logic          busy,
  output logic          done,
  output logic          no_sol
);
  localparam int NW = CW + 1;
  localparam logic [DW-1:0] VMIN_W  = DW'(VCO_MIN);
  localparam logic [DW-1:0] VMAX_W  = DW'(VCO_MAX);
  localparam logic [DW-1:0] UMIN_W  = DW'(U_MIN);
  localparam logic [DW-1:0] UMAX1_W = DW'(U_MAX + 1);
  localparam logic [DW-1:0] NMAX_W  = DW'(N_MAX);
  localparam logic [NW-1:0] NMIN_N  = NW'(N_MIN);
  localparam logic [NW-1:0] NMAX_N  = NW'(N_MAX);
  localparam logic [CW-1:0] MMIN_C  = CW'(M_MIN);
  localparam logic [CW-1:0] MMAX_C  = CW'(M_MAX);
  localparam logic [CW-1:0] NMIN_C  = CW'(N_MIN);

  function automatic logic [5:0] clamp_b(input logic [DW-1:0] v);
    if (v > DW'(BOUND_MAX)) return 6'(BOUND_MAX);
    if (v == '0) return 6'd1;
    return v[5:0];
  endfunction

  srch_st_e st;
  logic          launched;
  logic [DW-1:0] tgt, refk, tv, maxv, tvco, vco, best_err;
  logic [3:0]    pl, hi_idx, best_pl;
  logic [CW-1:0] m, best_m, best_n;
  logic [NW-1:0] n, n_hi;

  // named internal events for the checker
  logic          div_go, div_done, div_busy, div_take, cand_take;
  logic [DW-1:0] div_a, div_b, div_quot, div_rem;
  logic          in_win;
  logic [DW-1:0] err;

  logic [DW-1:0] m_w, n_w, ratio_w, tv_next;
  assign m_w     = DW'(m);
  assign n_w     = DW'(n);
  assign ratio_w = DW'(pl_ratio(pl));
  assign tv_next = tgt + div_quot;

  assign div_go   = (st inside {S_PCT, S_HI, S_LO, S_NDIV, S_VDIV, S_ODIV}) && !launched;
  assign div_take = launched && div_done;

  always_comb begin
    div_a = '0;
    div_b = DW'(1);
    case (st)
      S_PCT:  begin div_a = tgt;                   div_b = DW'(MARGIN_DIV); end
      S_HI:   begin div_a = maxv + tv - DW'(1);    div_b = tv;              end
      S_LO:   begin div_a = VMIN_W;                div_b = tv;              end
      S_NDIV: begin div_a = tvco * m_w;            div_b = refk;            end
      S_VDIV: begin div_a = refk * n_w;            div_b = m_w;             end
      S_ODIV: begin div_a = vco + (ratio_w >> 1);  div_b = ratio_w;         end
      default: ;
    endcase
  end

  pll_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_a), .divisor(div_b),
    .quot(div_quot), .rem(div_rem), .busy(div_busy), .done(div_done)
  );

  pll_cand_eval #(.DW(DW)) u_eval (
    .cand(div_quot), .win_lo(VMIN_W), .win_hi(maxv), .goal(tgt),
    .in_win(in_win), .err(err)
  );

  assign cand_take = (st == S_ODIV) && div_take && (err < best_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;   launched <= 1'b0;
      tgt <= '0;      refk <= '0;     tv <= '0;     maxv <= '0;
      tvco <= '0;     vco <= '0;      best_err <= '0;
      pl <= '0;       hi_idx <= '0;   best_pl <= '0;
      m <= '0;        best_m <= '0;   best_n <= '0;
      n <= '0;        n_hi <= '0;
      m_out <= '0;    n_out <= '0;    pl_out <= '0;
      done <= 1'b0;   no_sol <= 1'b0;
    end else begin
      done <= 1'b0;
      if (div_go) launched <= 1'b1;
      else if (div_take) launched <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tgt <= DW'(target_khz);  refk <= DW'(ref_khz);
          best_m <= MMAX_C;  best_n <= NMIN_C;  best_pl <= 4'd1;
          best_err <= '1;
          st <= S_PCT;
        end
        S_PCT: if (div_take) begin
          tv   <= tv_next;
          maxv <= (tv_next > VMAX_W) ? tv_next : VMAX_W;
          st   <= S_HI;
        end
        S_HI: if (div_take) begin
          hi_idx <= pl_first_idx(clamp_b(div_quot));
          st <= S_LO;
        end
        S_LO: if (div_take) begin
          pl <= pl_first_idx(clamp_b(div_quot));
          st <= S_PLSET;
        end
        S_PLSET: begin
          tvco <= tgt * ratio_w;
          m    <= MMIN_C;
          st   <= S_MCHK;
        end
        S_MCHK: begin
          if (refk < UMIN_W * m_w)        st <= S_PLNEXT;  // larger M only lowers it
          else if (refk >= UMAX1_W * m_w) st <= S_MNEXT;
          else                            st <= S_NDIV;
        end
        S_NDIV: if (div_take) begin
          if (div_quot > NMAX_W) st <= S_MNEXT;
          else begin
            n    <= div_quot[NW-1:0];
            n_hi <= div_quot[NW-1:0] + NW'(div_rem != '0);
            st   <= S_NCHK;
          end
        end
        S_NCHK: st <= (n < NMIN_N || n > NMAX_N) ? S_NNEXT : S_VDIV;
        S_VDIV: if (div_take) begin
          vco <= div_quot;
          st  <= in_win ? S_ODIV : S_NNEXT;
        end
        S_ODIV: if (div_take) begin
          if (cand_take) begin
            best_err <= err;  best_m <= m;
            best_n <= n[CW-1:0];  best_pl <= pl;
          end
          st <= (cand_take && err == '0) ? S_FIN : S_NNEXT;
        end
        S_NNEXT: begin
          if (n == n_hi) st <= S_MNEXT;
          else begin n <= n + 1'b1; st <= S_NCHK; end
        end
        S_MNEXT: begin
          if (m == MMAX_C) st <= S_PLNEXT;
          else begin m <= m + 1'b1; st <= S_MCHK; end
        end
        S_PLNEXT: begin
          if (pl == hi_idx) st <= S_FIN;
          else begin pl <= pl + 1'b1; st <= S_PLSET; end
        end
        S_FIN: begin
          m_out  <= best_m;  n_out <= best_n;  pl_out <= best_pl;
          no_sol <= (best_err == '1);
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
  parameter int CW      = 8,
  parameter int DW      = 40,
  parameter int VCO_MIN = 1000000,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          no_sol,
  input logic [CW-1:0] m_out,
  input logic [CW-1:0] n_out,
  input logic [3:0]    pl_out,
  input logic          div_go,
  input logic          div_busy,
  input logic          cand_take,
  input logic [DW-1:0] vco,
  input logic [DW-1:0] maxv
);
  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(m_out) && $stable(n_out) && $stable(pl_out) && $stable(no_sol)));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_sol) |-> (m_out >= CW'(M_MIN) && m_out <= CW'(M_MAX) &&
                           n_out >= CW'(N_MIN) && n_out <= CW'(N_MAX) && pl_out <= 4'd14));

  p_vco_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_take |-> (vco >= DW'(VCO_MIN) && vco <= maxv));

  p_serial_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

  p_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_sol) |-> (m_out == CW'(M_MAX) && n_out == CW'(N_MIN) && pl_out == 4'd1));
endmodule

bind pll_coef_search pll_coef_search_chk #(
  .CW(CW), .DW(DW), .VCO_MIN(VCO_MIN), .M_MIN(M_MIN), .M_MAX(M_MAX),
  .N_MIN(N_MIN), .N_MAX(N_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .no_sol(no_sol), .m_out(m_out), .n_out(n_out), .pl_out(pl_out),
  .div_go(div_go), .div_busy(div_busy), .cand_take(cand_take),
  .vco(vco), .maxv(maxv)
);

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint VLO = 1000000, VHI = 2064000, ULO = 12000, UHI = 38000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] target_khz = '0, ref_khz = '0;
  logic [7:0]  m_out, n_out;
  logic [3:0]  pl_out;
  logic        busy, done, no_sol;
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_coef_search u_pll_coef_search (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .ref_khz(ref_khz), .m_out(m_out), .n_out(n_out), .pl_out(pl_out),
    .busy(busy), .done(done), .no_sol(no_sol)
  );

  function automatic longint ratio_of(int i);
    if (i < 6) return longint'(i + 1);
    case (i)
      6: return 8;   7: return 10;  8: return 12;  9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int idx_for(longint b);
    for (int i = 0; i < 14; i++) if (ratio_of(i) >= b) return i;
    return 14;
  endfunction

  function automatic longint lim(longint v);
    return (v < 1) ? 1 : ((v > 32) ? 32 : v);
  endfunction

  task automatic model(input longint t, input longint r,
                       output int bm, output int bn, output int bp, output bit nos);
    longint w, top, best, tvc, nl, nh, v, est, dlt;
    int lo_i, hi_i;
    bit hit, fin;
    w   = t + t / 50;
    top = (w > VHI) ? w : VHI;
    hi_i = idx_for(lim((top + w - 1) / w));
    lo_i = idx_for(lim(VLO / w));
    bm = 255; bn = 8; bp = 1; best = 64'sh7fffffffffffffff; hit = 0; fin = 0;
    for (int p = lo_i; p <= hi_i && !fin; p++) begin
      tvc = t * ratio_of(p);
      for (int mm = 1; mm <= 255 && !fin; mm++) begin
        if (r / mm < ULO || r / mm > UHI) continue;
        nl = tvc * mm / r;
        nh = (tvc * mm + r - 1) / r;
        if (nl > 255) continue;
        for (longint nn = nl; nn <= nh && !fin; nn++) begin
          if (nn < 8 || nn > 255) continue;
          v = r * nn / mm;
          if (v < VLO || v > top) continue;
          est = (v + ratio_of(p) / 2) / ratio_of(p);
          dlt = (est > t) ? est - t : t - est;
          if (dlt < best) begin
            best = dlt; bm = mm; bn = int'(nn); bp = p; hit = 1;
            if (dlt == 0) fin = 1;
          end
        end
      end
    end
    nos = !hit;
  endtask

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  task automatic search(input int t, input int r, input string tag,
                        input bit overlap, input int t2);
    int em, en, ep; bit ens; bit seen;
    model(t, r, em, en, ep, ens);
    @(negedge clk); target_khz = 24'(t); ref_khz = 24'(r); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", $sformatf("%0b", busy), "1");
    if (overlap) begin
      repeat (3) @(negedge clk);
      target_khz = 24'(t2); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    seen = 0;
    for (int c = 0; c < 60000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen, {tag, " completion"}, "timeout", "done");
    if (!seen) return;
    check(busy === 1'b0, "R3 busy low at done", $sformatf("%0b", busy), "0");
    check(m_out == 8'(em) && n_out == 8'(en) && pl_out == 4'(ep) && no_sol == ens, tag,
          $sformatf("m=%0d n=%0d pl=%0d nosol=%0d", m_out, n_out, pl_out, no_sol),
          $sformatf("m=%0d n=%0d pl=%0d nosol=%0d", em, en, ep, ens));
    @(negedge clk);
    check(done === 1'b0 && m_out == 8'(em) && n_out == 8'(en) && pl_out == 4'(ep),
          "R3 single pulse and hold",
          $sformatf("done=%0b m=%0d n=%0d pl=%0d", done, m_out, n_out, pl_out),
          $sformatf("done=0 m=%0d n=%0d pl=%0d", em, en, ep));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nbad++; nchk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check({m_out, n_out, pl_out, done, busy, no_sol} == '0, "R1 in reset",
          $sformatf("%0h", {m_out, n_out, pl_out, done, busy, no_sol}), "0");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({m_out, n_out, pl_out, done, busy, no_sol} == '0, "R1 after release",
          $sformatf("%0h", {m_out, n_out, pl_out, done, busy, no_sol}), "0");

    search(100000, 27000,   "R4 R8 nominal", 0, 0);
    search(20000, 12000,    "R9 R4 last index, nothing fits", 0, 0);
    search(2500000, 12000,  "R7 raised window top", 0, 0);
    search(108000, 12000,   "R8 exact hit", 0, 0);
    search(150000, 11000,   "R5 reference below window", 0, 0);
    search(150000, 40000,   "R5 M=1 above window", 0, 0);
    search(400000, 38000,   "R6 coarse reference", 0, 0);
    search(250000, 24000,   "R2 start ignored while busy", 1, 777000);
    for (int k = 0; k < 10; k++)
      search(int'($urandom_range(900000, 60000)), int'($urandom_range(40000, 12000)),
             "R4 R5 R6 R7 R8 random", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule